// File: doc/BRIEF.md
# Configuration Fetch Request Engine

This block sits beside a processing element. It loads a configuration into local configuration memory when the element asks for one that is not already resident. A request names a configuration id. The engine finds the id's entry in its descriptor table, which gives a slot count, a base address in the remote server and a base address in local memory. For each slot the engine sends one request packet, waits for the server's move reply and writes the reply's data words into local memory. Only then does it ask for the next slot.

Each packet is one 32-bit word. Bits [31:30] carry the kind: 01 for a request, 10 for a move header and 11 for a data word. The descriptor table is derived from the parameters. A configuration with zero slots counts as empty and loads at once. A request for the configuration that is already resident finishes without any network traffic. A malformed reply ends the fetch and raises a one-cycle error pulse.

Top module: `cfg_fetch_engine`

## Requirements
- R1: After reset, busy_o, done_o, err_o, loaded_vld_o, pkt_out_valid_o and mem_we_o are all 0.
- R2: Configuration id i uses i mod (MAX_SLOTS+1) slots, server base i*MAX_SLOTS and local base i*MAX_SLOTS*SLOT_LEN. An id with zero slots sends no packet, pulses done_o in the cycle after the request and becomes the loaded id.
- R3: A fetch that needs traffic puts its first request on pkt_out in the cycle after req_valid_i is sampled. The request has kind 01 in bits [31:30], the server address in [23:16], the local address in [15:8] and zeros in all other bits.
- R4: Each later slot request has a server address one higher than the one before and a local address SLOT_LEN higher.
- R5: The move header has kind 10, the destination in [15:8] and the word count in [7:0]. A data word has kind 11 and its payload in [29:0]. Each data word sampled while receiving appears on the write port in the next cycle, at the header destination plus its index.
- R6: pkt_out_valid_o is high for exactly one cycle per slot. Only one request is outstanding at a time. The next request appears in the same cycle as the write strobe of the previous slot's last word.
- R7: done_o is high for one cycle, in the same cycle as the write strobe of the final word. loaded_vld_o and loaded_id_o take the new id in that same cycle.
- R8: A request for the id that is already loaded sends no packet and pulses done_o in the next cycle.
- R9: Three reply faults abort the fetch. These are a header whose count is not SLOT_LEN, a header arriving before the current slot's words are complete, and a data word arriving while a header is expected. In each case err_o pulses for one cycle in the cycle after the fault, busy_o falls at the same time, and loaded_vld_o stays 0.
- R10: A request sampled while busy is ignored. It sends no packet and does not change the loaded id.
- R11: busy_o is high from the cycle after a missed request until the final word. It is low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request strobe |
| req_id_i | input | ID_W | Requested configuration id |
| pkt_out_valid_o | output | 1 | Request packet valid |
| pkt_out_data_o | output | 32 | Request packet word |
| pkt_in_valid_i | input | 1 | Reply word valid |
| pkt_in_data_i | input | 32 | Reply word (header or data) |
| mem_we_o | output | 1 | Local memory write strobe |
| mem_addr_o | output | 8 | Local memory write address |
| mem_wdata_o | output | 30 | Local memory write data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Load complete pulse |
| err_o | output | 1 | Fetch aborted pulse |
| loaded_vld_o | output | 1 | A configuration is resident |
| loaded_id_o | output | ID_W | Id of the resident configuration |

## Verification
Inputs change only on the falling edge, so every result is read at the next falling edge, exactly one register stage later. The first request packet, the done pulse for a hit or an empty id, each write strobe, the following request or done, and the error pulse all fall one cycle after the input that caused them. After each pulse the bench waits one more cycle to confirm that it has dropped. The sweep covers every id in turn, followed by a repeat of the same id. Each fault kind and a request made while busy are then injected, and every expected field is computed from the id, the slot and the word index.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;
  localparam int PKT_W  = 32;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 30;

  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_REQ  = 2'b01,
    PK_MOVE = 2'b10,
    PK_DATA = 2'b11
  } pkt_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_HDR,
    ST_RECV,
    ST_FINISH
  } fetch_state_e;
endpackage

// File: rtl/cfg_desc_table.sv
module cfg_desc_table
  import cfg_fetch_pkg::*;
#(
  parameter int NUM_CFG   = 8,
  parameter int MAX_SLOTS = 3,
  parameter int SLOT_LEN  = 4,
  parameter int ID_W      = 3,
  parameter int SC_W      = 2
) (
  input  logic [ID_W-1:0]   id_i,
  output logic [SC_W-1:0]   slots_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  logic [SC_W-1:0]   slots_tab [NUM_CFG];
  logic [ADDR_W-1:0] src_tab   [NUM_CFG];
  logic [ADDR_W-1:0] dst_tab   [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_ent
    assign slots_tab[g] = SC_W'(g % (MAX_SLOTS + 1));
    assign src_tab[g]   = ADDR_W'(g * MAX_SLOTS);
    assign dst_tab[g]   = ADDR_W'(g * MAX_SLOTS * SLOT_LEN);
  end

  assign slots_o = slots_tab[id_i];
  assign src_o   = src_tab[id_i];
  assign dst_o   = dst_tab[id_i];
endmodule

// File: rtl/cfg_slot_writer.sv
module cfg_slot_writer
  import cfg_fetch_pkg::*;
#(
  parameter int SLOT_LEN = 4,
  parameter int WC_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              word_vld_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              last_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [WC_W-1:0]   cnt_q;

  assign last_o = word_vld_i && (cnt_q == WC_W'(SLOT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      cnt_q       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= word_vld_i;
      if (arm_i) begin
        ptr_q <= base_i;
        cnt_q <= '0;
      end else if (word_vld_i) begin
        ptr_q       <= ptr_q + 1'b1;
        cnt_q       <= cnt_q + 1'b1;
        mem_addr_o  <= ptr_q;
        mem_wdata_o <= word_i;
      end
    end
  end
endmodule

// File: rtl/cfg_fetch_engine.sv
module cfg_fetch_engine
  import cfg_fetch_pkg::*;
#(
  parameter int NUM_CFG   = 8,
  parameter int MAX_SLOTS = 3,
  parameter int SLOT_LEN  = 4,
  localparam int ID_W     = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1,
  localparam int SC_W     = $clog2(MAX_SLOTS + 1),
  localparam int WC_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              pkt_out_valid_o,
  output logic [PKT_W-1:0]  pkt_out_data_o,
  input  logic              pkt_in_valid_i,
  input  logic [PKT_W-1:0]  pkt_in_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              loaded_vld_o,
  output logic [ID_W-1:0]   loaded_id_o
);
  fetch_state_e      state_q;
  logic [ID_W-1:0]   cur_id_q;
  logic [SC_W-1:0]   slots_q, slot_idx_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              err_q;

  logic [SC_W-1:0]   d_slots;
  logic [ADDR_W-1:0] d_src, d_dst;
  pkt_kind_e         in_kind;
  logic              hdr_ok, word_vld, word_last, arm;

  cfg_desc_table #(
    .NUM_CFG(NUM_CFG), .MAX_SLOTS(MAX_SLOTS), .SLOT_LEN(SLOT_LEN),
    .ID_W(ID_W), .SC_W(SC_W)
  ) u_desc (
    .id_i(req_id_i), .slots_o(d_slots), .src_o(d_src), .dst_o(d_dst)
  );

  assign in_kind  = pkt_kind_e'(pkt_in_data_i[31:30]);
  assign hdr_ok   = (in_kind == PK_MOVE) && (pkt_in_data_i[7:0] == 8'(SLOT_LEN));
  assign arm      = (state_q == ST_WAIT_HDR) && pkt_in_valid_i && hdr_ok;
  assign word_vld = (state_q == ST_RECV) && pkt_in_valid_i && (in_kind == PK_DATA);

  cfg_slot_writer #(.SLOT_LEN(SLOT_LEN), .WC_W(WC_W)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .arm_i(arm), .base_i(pkt_in_data_i[15:8]),
    .word_vld_i(word_vld), .word_i(pkt_in_data_i[DATA_W-1:0]),
    .last_o(word_last),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cur_id_q     <= '0;
      slots_q      <= '0;
      slot_idx_q   <= '0;
      src_q        <= '0;
      dst_q        <= '0;
      err_q        <= 1'b0;
      loaded_vld_o <= 1'b0;
      loaded_id_o  <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (loaded_vld_o && req_id_i == loaded_id_o) begin
            state_q <= ST_FINISH;
          end else if (d_slots == '0) begin
            state_q      <= ST_FINISH;
            loaded_vld_o <= 1'b1;
            loaded_id_o  <= req_id_i;
          end else begin
            state_q      <= ST_ISSUE;
            loaded_vld_o <= 1'b0;  // local memory is about to be overwritten
            cur_id_q     <= req_id_i;
            slots_q      <= d_slots;
            slot_idx_q   <= '0;
            src_q        <= d_src;
            dst_q        <= d_dst;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT_HDR;
        ST_WAIT_HDR: if (pkt_in_valid_i) begin
          if (hdr_ok) state_q <= ST_RECV;
          else begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        ST_RECV: if (pkt_in_valid_i) begin
          if (in_kind != PK_DATA) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else if (word_last) begin
            if (slot_idx_q == slots_q - SC_W'(1)) begin
              state_q      <= ST_FINISH;
              loaded_vld_o <= 1'b1;
              loaded_id_o  <= cur_id_q;
            end else begin
              state_q    <= ST_ISSUE;
              slot_idx_q <= slot_idx_q + SC_W'(1);
              src_q      <= src_q + 1'b1;
              dst_q      <= dst_q + ADDR_W'(SLOT_LEN);
            end
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pkt_out_valid_o = (state_q == ST_ISSUE);
  assign pkt_out_data_o  = pkt_out_valid_o ? {PK_REQ, 6'b0, src_q, dst_q, 8'b0} : '0;
  assign busy_o          = (state_q == ST_ISSUE) || (state_q == ST_WAIT_HDR) || (state_q == ST_RECV);
  assign done_o          = (state_q == ST_FINISH);
  assign err_o           = err_q;
endmodule

// File: rtl/cfg_fetch_checker.sv
module cfg_fetch_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pkt_out_valid_o,
  input logic mem_we_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic loaded_vld_o
);
  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_out_valid_o |=> !pkt_out_valid_o);
  assert_req_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_out_valid_o |-> busy_o);
  assert_done_loaded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (loaded_vld_o && !busy_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_write_in_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (busy_o || done_o));
  assert_err_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !loaded_vld_o));
  assert_excl_events_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, pkt_out_valid_o}));
endmodule

bind cfg_fetch_engine cfg_fetch_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_out_valid_o(pkt_out_valid_o),
  .mem_we_o(mem_we_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .loaded_vld_o(loaded_vld_o)
);

// File: tb/tb_cfg_fetch_engine.sv
module tb_cfg_fetch_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_id = '0;
  logic        pkt_out_valid;
  logic [31:0] pkt_out_data;
  logic        pkt_in_valid = 1'b0;
  logic [31:0] pkt_in_data = '0;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [29:0] mem_wdata;
  logic        busy, done, err, loaded_vld;
  logic [2:0]  loaded_id;

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_vld = 0;
  int exp_id = 0;

  always #5 clk = ~clk;

  cfg_fetch_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .pkt_out_valid_o(pkt_out_valid), .pkt_out_data_o(pkt_out_data),
    .pkt_in_valid_i(pkt_in_valid), .pkt_in_data_i(pkt_in_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .busy_o(busy), .done_o(done), .err_o(err),
    .loaded_vld_o(loaded_vld), .loaded_id_o(loaded_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_abort(input string tag);
    chk({tag, " err pulse"}, int'(err), 1);
    chk({tag, " busy low"}, int'(busy), 0);
    chk({tag, " loaded_vld"}, int'(loaded_vld), 0);
    @(negedge clk);
    chk({tag, " err one cycle"}, int'(err), 0);
    exp_vld = 0;
  endtask

  // mode: 0 normal, 1 bad length, 2 short reply, 3 stray data, 4 request while busy
  task automatic fetch(input int id, input int mode);
    int ns;
    bit hit;
    ns  = id % 4;
    hit = exp_vld && (id == exp_id);
    @(negedge clk);
    req_valid = 1'b1;
    req_id    = 3'(id);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit || ns == 0) begin
      chk(hit ? "R8 done" : "R2 done", int'(done), 1);
      chk(hit ? "R8 no packet" : "R2 no packet", int'(pkt_out_valid), 0);
      chk("R7 loaded_id", int'(loaded_id), id);
      chk("R7 loaded_vld", int'(loaded_vld), 1);
      exp_vld = 1;
      exp_id  = id;
      @(negedge clk);
      chk("R7 done one cycle", int'(done), 0);
      return;
    end
    for (int s = 0; s < ns; s++) begin
      int sb, db;
      sb = id * 3 + s;
      db = id * 12 + s * 4;
      chk("R6 request valid", int'(pkt_out_valid), 1);
      chk("R3 kind", int'(pkt_out_data[31:30]), 1);
      chk(s == 0 ? "R3 src" : "R4 src", int'(pkt_out_data[23:16]), sb);
      chk(s == 0 ? "R3 dst" : "R4 dst", int'(pkt_out_data[15:8]), db);
      chk("R3 zero bits", int'({pkt_out_data[29:24], pkt_out_data[7:0]}), 0);
      @(negedge clk);
      chk("R11 busy waiting", int'(busy), 1);
      chk("R6 single request", int'(pkt_out_valid), 0);
      if (mode == 4 && s == 0) begin
        req_valid = 1'b1;
        req_id    = 3'((id + 1) % 8);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 no packet", int'(pkt_out_valid), 0);
        chk("R10 still busy", int'(busy), 1);
      end
      if (mode == 3 && s == 0) begin
        pkt_in_valid = 1'b1;
        pkt_in_data  = {2'b11, 30'h5};
        @(negedge clk);
        pkt_in_valid = 1'b0;
        expect_abort("R9 stray data");
        return;
      end
      pkt_in_valid = 1'b1;
      pkt_in_data  = {2'b10, 14'b0, 8'(db), (mode == 1) ? 8'd3 : 8'd4};
      @(negedge clk);
      pkt_in_valid = 1'b0;
      if (mode == 1) begin
        expect_abort("R9 bad length");
        return;
      end
      for (int w = 0; w < 4; w++) begin
        if (mode == 2 && w == 2) begin
          pkt_in_valid = 1'b1;
          pkt_in_data  = {2'b10, 14'b0, 8'(db), 8'd4};
          @(negedge clk);
          pkt_in_valid = 1'b0;
          expect_abort("R9 short reply");
          return;
        end
        pkt_in_valid = 1'b1;
        pkt_in_data  = {2'b11, 6'b0, 8'(id), 8'(s), 8'(w)};
        @(negedge clk);
        pkt_in_valid = 1'b0;
        chk("R5 write strobe", int'(mem_we), 1);
        chk("R5 write addr", int'(mem_addr), db + w);
        chk("R5 write data", int'(mem_wdata), (id << 16) | (s << 8) | w);
        if (w == 3 && s == ns - 1) begin
          chk("R7 done", int'(done), 1);
          chk("R7 loaded_vld", int'(loaded_vld), 1);
          chk("R7 loaded_id", int'(loaded_id), id);
          chk("R11 busy low at done", int'(busy), 0);
        end else if (w == 3) begin
          chk("R6 no early done", int'(done), 0);
        end
      end
    end
    exp_vld = 1;
    exp_id  = id;
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    chk("R6 no extra request", int'(pkt_out_valid), 0);
    chk("R10 loaded id kept", int'(loaded_id), id);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 loaded_vld", int'(loaded_vld), 0);
    chk("R1 pkt_out", int'(pkt_out_valid), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    for (int id = 0; id < 8; id++) begin
      fetch(id, 0);
      fetch(id, 0);  // repeat is a hit
    end
    fetch(3, 1);
    fetch(2, 2);
    fetch(1, 3);
    fetch(3, 0);
    fetch(5, 4);
    fetch(5, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule